// File: doc/BRIEF.md
# One-Wire ROM Search Triplet Engine

This block sits beside a one-wire bus master and takes over the bit-level work of a ROM search. After the host has issued a bus reset and the search command byte, it raises `search_en`. From then on every byte the host loads carries four direction hints at its odd bit positions (bits 1, 3, 5, 7, lowest ROM position first). For each of the four ROM positions the engine runs a triplet on the line: read the true bit, read the complement, then write the chosen direction. It packs the four outcomes into one response byte and raises the receive-full flag, as an ordinary byte read would.

Sixteen such exchanges cover a 64-bit identity. The ROM bits of exchange `i` are identity bits `4i` to `4i+3`. The even bits of every response flag the positions where two or more devices disagreed, so the host can choose the next branch. A hint byte of 0x00 takes the 0 branch at every disagreement.

The engine is a four-state machine. **IDLE** moves to **READ_TRUE** on an accepted load. **READ_TRUE** moves to **READ_COMP** at the end of its slot. **READ_COMP** moves to **WRITE_DIR** at the end of its slot. **WRITE_DIR** returns to **READ_TRUE** for the next position, or to **IDLE** after the fourth position, delivering the byte. Every slot lasts `SLOT_LEN` cycles.

Top module: `owsa_search_accel`

## Requirements
- R1: While reset is held and after its release, `busy`, `rx_full`, `line_drive_low` and `rx_byte` are all 0.
- R2: A load is accepted only when `search_en` is 1 and the engine is idle. A load with `search_en` at 0, or a load made while busy, has no effect: no slot starts, the running group is not restarted, and its response is unchanged.
- R3: A group consists of exactly 12 slots of `SLOT_LEN` cycles each: a true-bit read, a complement read and a write for each of four positions. Reads and write-1 slots pull the line low for `SHORT_LOW` cycles, and write-0 slots for `LONG_LOW` cycles. The line is sampled `SAMPLE_AT` cycles into a read slot. The line is never pulled while idle.
- R4: When both reads return 0, the position's discrepancy flag is 1. The engine writes the hint for that position (tx bit 2k+1 for position k), and that hint is the reported ROM bit.
- R5: When the two reads differ, the discrepancy flag is 0, and the true-bit read value is written and reported as the ROM bit.
- R6: When both reads return 1 (no device answering), the discrepancy flag and the ROM bit are both 1, and a 1 is written.
- R7: Response bit 2k+1 holds the ROM bit of position k, and bit 2k holds its discrepancy flag, for k = 0..3.
- R8: `rx_full` rises exactly 12·`SLOT_LEN` clock edges after the edge that accepted the load. `busy` is high for those cycles and falls on the same edge.
- R9: `rx_full` stays high until `rx_ack` is pulsed. `rx_byte` changes only on the edge that completes a group.
- R10: Sixteen exchanges give a 64-bit identity (exchange i supplying bits 4i..4i+3) that equals the ROM of a device present on the line. With one device, it equals that device's ROM.
- R11: Loading 0x00 makes every hint 0, so every disagreement resolves to 0.
- R12: `search_en` is looked at only when a load is accepted. Clearing it while a group runs does not stop or alter that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_en | input | 1 | Accelerator mode enable from the command register |
| tx_load | input | 1 | Host loads a hint byte this cycle |
| tx_byte | input | BYTE_W | Hint byte; hints at odd bits |
| rx_ack | input | 1 | Host has read the response; clears `rx_full` |
| rx_byte | output | BYTE_W | Packed response: odd bits ROM, even bits discrepancy |
| rx_full | output | 1 | Receive buffer full |
| busy | output | 1 | A group is in progress |
| line_drive_low | output | 1 | Pull the one-wire line low |
| line_sense | input | 1 | Sampled level of the one-wire line |

## Verification
The response byte and `rx_full` are due 12·`SLOT_LEN` edges after the accepting edge. The bench therefore counts falling clock edges from the load and requires `rx_full` to first appear at count 12·`SLOT_LEN`+1, then compares `rx_byte` there. Line pulse widths and slot counts are measured on falling edges as they happen. The wire model answers each slot one falling edge after the pull begins, well ahead of the sample point, so the read value is settled when the engine latches it. The acknowledge is checked one edge after it is driven, and the hold of `rx_full` is checked thirty cycles later.

// File: rtl/owsa_pkg.sv
package owsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_TRUE = 2'd1,
        ST_READ_COMP = 2'd2,
        ST_WRITE_DIR = 2'd3
    } owsa_state_e;

    typedef struct packed {
        logic rom_bit;
        logic disc;
        logic wr_bit;
    } owsa_verdict_t;

endpackage

// File: rtl/owsa_slot_timer.sv
module owsa_slot_timer #(
    parameter int SLOT_LEN  = 16,
    parameter int SHORT_LOW = 2,
    parameter int LONG_LOW  = 12,
    parameter int SAMPLE_AT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_low,
    output logic drive_low,
    output logic sample_now,
    output logic slot_end
);
    localparam int CW = $clog2(SLOT_LEN);
    localparam logic [CW-1:0] LAST_C  = CW'(SLOT_LEN - 1);
    localparam logic [CW-1:0] SHORT_C = CW'(SHORT_LOW);
    localparam logic [CW-1:0] LONG_C  = CW'(LONG_LOW);
    localparam logic [CW-1:0] SAMP_C  = CW'(SAMPLE_AT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_C) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign slot_end   = run && (cnt_q == LAST_C);
    assign sample_now = run && (cnt_q == SAMP_C);
    assign drive_low  = run && (cnt_q < (long_low ? LONG_C : SHORT_C));

endmodule

// File: rtl/owsa_triplet_resolve.sv
module owsa_triplet_resolve
    import owsa_pkg::*;
(
    input  logic          rd_true,
    input  logic          rd_comp,
    input  logic          hint,
    output owsa_verdict_t verdict
);
    always_comb begin
        unique case ({rd_true, rd_comp})
            2'b00:   verdict = '{rom_bit: hint, disc: 1'b1, wr_bit: hint};
            2'b01:   verdict = '{rom_bit: 1'b0, disc: 1'b0, wr_bit: 1'b0};
            2'b10:   verdict = '{rom_bit: 1'b1, disc: 1'b0, wr_bit: 1'b1};
            default: verdict = '{rom_bit: 1'b1, disc: 1'b1, wr_bit: 1'b1};
        endcase
    end
endmodule

// File: rtl/owsa_resp_pack.sv
module owsa_resp_pack
    import owsa_pkg::*;
#(
    parameter int GROUP_BITS = 4
) (
    input  logic [2*GROUP_BITS-1:0]         work,
    input  logic [$clog2(GROUP_BITS)-1:0]   idx,
    input  owsa_verdict_t                   verdict,
    output logic [2*GROUP_BITS-1:0]         next
);
    localparam int IW = $clog2(GROUP_BITS);

    for (genvar k = 0; k < GROUP_BITS; k++) begin : g_pos
        assign next[2*k+1] = (idx == IW'(k)) ? verdict.rom_bit : work[2*k+1];
        assign next[2*k]   = (idx == IW'(k)) ? verdict.disc    : work[2*k];
    end
endmodule

// File: rtl/owsa_search_accel.sv
module owsa_search_accel
    import owsa_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int SLOT_LEN  = 16,
    parameter int SHORT_LOW = 2,
    parameter int LONG_LOW  = 12,
    parameter int SAMPLE_AT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              search_en,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_ack,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_full,
    output logic              busy,
    output logic              line_drive_low,
    input  logic              line_sense
);
    localparam int GROUP_BITS = BYTE_W / 2;
    localparam int IW         = $clog2(GROUP_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(GROUP_BITS - 1);

    owsa_state_e state_q, state_d;

    logic [GROUP_BITS-1:0] hint_in, hint_q, even_in;
    logic [IW-1:0]         idx_q;
    logic                  rd_true_q, rd_comp_q;
    logic [BYTE_W-1:0]     work_q, work_next, rx_byte_q;
    logic                  rx_full_q;
    logic                  accept, run, long_low;
    logic                  drive_low, sample_now, slot_end, group_done;
    logic                  unused_even_bits;
    owsa_verdict_t         verdict;

    // Hints ride at odd positions, mirroring the response layout.
    for (genvar k = 0; k < GROUP_BITS; k++) begin : g_hint
        assign hint_in[k] = tx_byte[2*k+1];
        assign even_in[k] = tx_byte[2*k];
    end
    assign unused_even_bits = ^even_in;

    assign accept     = tx_load && search_en && (state_q == ST_IDLE);
    assign run        = (state_q != ST_IDLE);
    assign long_low   = (state_q == ST_WRITE_DIR) && !verdict.wr_bit;
    assign group_done = slot_end && (state_q == ST_WRITE_DIR) && (idx_q == LAST_IDX);

    owsa_slot_timer #(
        .SLOT_LEN  (SLOT_LEN),
        .SHORT_LOW (SHORT_LOW),
        .LONG_LOW  (LONG_LOW),
        .SAMPLE_AT (SAMPLE_AT)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .long_low   (long_low),
        .drive_low  (drive_low),
        .sample_now (sample_now),
        .slot_end   (slot_end)
    );

    owsa_triplet_resolve resolve_i (
        .rd_true (rd_true_q),
        .rd_comp (rd_comp_q),
        .hint    (hint_q[idx_q]),
        .verdict (verdict)
    );

    owsa_resp_pack #(
        .GROUP_BITS (GROUP_BITS)
    ) pack_i (
        .work    (work_q),
        .idx     (idx_q),
        .verdict (verdict),
        .next    (work_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_READ_TRUE;
            end
            ST_READ_TRUE: begin
                if (slot_end) state_d = ST_READ_COMP;
            end
            ST_READ_COMP: begin
                if (slot_end) state_d = ST_WRITE_DIR;
            end
            ST_WRITE_DIR: begin
                if (slot_end) state_d = (idx_q == LAST_IDX) ? ST_IDLE : ST_READ_TRUE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hint_q    <= '0;
            idx_q     <= '0;
            rd_true_q <= 1'b0;
            rd_comp_q <= 1'b0;
            work_q    <= '0;
            rx_byte_q <= '0;
            rx_full_q <= 1'b0;
        end else begin
            if (accept) begin
                hint_q <= hint_in;
                idx_q  <= '0;
                work_q <= '0;
            end
            if (sample_now && (state_q == ST_READ_TRUE)) begin
                rd_true_q <= line_sense;
            end
            if (sample_now && (state_q == ST_READ_COMP)) begin
                rd_comp_q <= line_sense;
            end
            if (slot_end && (state_q == ST_WRITE_DIR)) begin
                work_q <= work_next;
                idx_q  <= idx_q + IW'(1);
            end
            if (group_done) begin
                rx_byte_q <= work_next;
            end
            if (group_done) begin
                rx_full_q <= 1'b1;
            end else if (rx_ack) begin
                rx_full_q <= 1'b0;
            end
        end
    end

    assign rx_byte        = rx_byte_q;
    assign rx_full        = rx_full_q;
    assign busy           = run;
    assign line_drive_low = drive_low;

endmodule

// File: rtl/owsa_search_accel_chk.sv
module owsa_search_accel_chk #(
    parameter int BYTE_W   = 8,
    parameter int SLOT_LEN = 16,
    parameter int LONG_LOW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              search_en,
    input logic              tx_load,
    input logic              rx_ack,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rx_full,
    input logic              busy,
    input logic              line_drive_low
);
    localparam int GROUP_CYC = (BYTE_W / 2) * 3 * SLOT_LEN;
    localparam int BW        = $clog2(GROUP_CYC + 2) + 1;
    localparam int LW        = $clog2(LONG_LOW + 2) + 1;

    logic [BW-1:0] busy_run;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
            low_run  <= '0;
        end else begin
            busy_run <= busy ? ((busy_run == '1) ? busy_run : busy_run + BW'(1)) : '0;
            low_run  <= line_drive_low ? ((low_run == '1) ? low_run : low_run + LW'(1)) : '0;
        end
    end

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_drive_low);

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LW'(LONG_LOW));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && search_en && !busy) |=> busy);

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !search_en && !busy) |=> !busy);

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_ack) |=> rx_full);

    p_byte_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rx_byte));

    p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> ($past(busy) && !busy));

    p_group_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= BW'(GROUP_CYC));

endmodule

bind owsa_search_accel owsa_search_accel_chk #(
    .BYTE_W   (BYTE_W),
    .SLOT_LEN (SLOT_LEN),
    .LONG_LOW (LONG_LOW)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .search_en      (search_en),
    .tx_load        (tx_load),
    .rx_ack         (rx_ack),
    .rx_byte        (rx_byte),
    .rx_full        (rx_full),
    .busy           (busy),
    .line_drive_low (line_drive_low)
);

// File: tb/owsa_search_accel_tb_top.sv
`timescale 1ns/1ps
module owsa_search_accel_tb_top;
    localparam int SLOT  = 16;
    localparam int SHORT = 2;
    localparam int LONG  = 12;
    localparam int SAMP  = 5;
    localparam int GROUP_CYC = 12 * SLOT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       search_en = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_ack = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_full, busy, line_drive_low, line_sense;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    owsa_search_accel #(
        .BYTE_W(8), .SLOT_LEN(SLOT), .SHORT_LOW(SHORT), .LONG_LOW(LONG), .SAMPLE_AT(SAMP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .search_en(search_en), .tx_load(tx_load),
        .tx_byte(tx_byte), .rx_ack(rx_ack), .rx_byte(rx_byte), .rx_full(rx_full),
        .busy(busy), .line_drive_low(line_drive_low), .line_sense(line_sense)
    );

    // ---------------- wire and device model ----------------
    logic [63:0] dev_rom [4];
    logic [3:0]  dev_present = 4'b0;
    logic [3:0]  dev_alive = 4'b0;
    logic [1:0]  ph = 2'd0;
    logic [5:0]  bpos = 6'd0;
    logic [4:0]  scnt = 5'd31;
    logic        drv_prev = 1'b0;
    logic        dev_restart = 1'b0;
    logic        dev_pull;

    always_comb begin
        dev_pull = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (dev_alive[i] && scnt < 5'd8 &&
                ((ph == 2'd0 && !dev_rom[i][bpos]) || (ph == 2'd1 && dev_rom[i][bpos])))
                dev_pull = 1'b1;
        end
    end
    assign line_sense = !(line_drive_low || dev_pull);

    always @(negedge clk) begin
        drv_prev <= line_drive_low;
        if (dev_restart) begin
            dev_alive <= dev_present;
            ph <= 2'd0;
            bpos <= 6'd0;
            scnt <= 5'd31;
        end else if (line_drive_low && !drv_prev) begin
            scnt <= 5'd0;
        end else if (scnt != 5'd31) begin
            scnt <= scnt + 5'd1;
            if (scnt == 5'd6 && ph == 2'd2) begin
                for (int i = 0; i < 4; i++)
                    if (dev_rom[i][bpos] != line_sense) dev_alive[i] <= 1'b0;
            end
            if (scnt == 5'd8) begin
                ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
                if (ph == 2'd2) bpos <= bpos + 6'd1;
            end
        end
    end

    // ---------------- line monitor ----------------
    int  rise_cnt = 0;
    int  bad_pulse = 0;
    int  run_len = 0;
    logic mon_prev = 1'b0;

    always @(negedge clk) begin
        if (line_drive_low) begin
            run_len <= run_len + 1;
        end else begin
            if (run_len != 0 && run_len != SHORT && run_len != LONG) bad_pulse <= bad_pulse + 1;
            run_len <= 0;
        end
        if (line_drive_low && !mon_prev) rise_cnt <= rise_cnt + 1;
        mon_prev <= line_drive_low;
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    logic [3:0] mdl_alive;

    task automatic model_group(input int g, input logic [7:0] hb, output logic [7:0] resp);
        for (int k = 0; k < 4; k++) begin
            int pos;
            bit any0, any1, rt, rc, w, d;
            pos = 4 * g + k;
            any0 = 0; any1 = 0;
            for (int i = 0; i < 4; i++)
                if (mdl_alive[i]) begin
                    if (dev_rom[i][pos]) any1 = 1; else any0 = 1;
                end
            rt = !any0;
            rc = !any1;
            if (!rt && !rc) begin w = hb[2*k+1]; d = 1; end
            else if (rt != rc) begin w = rt; d = 0; end
            else begin w = 1; d = 1; end
            for (int i = 0; i < 4; i++)
                if (mdl_alive[i] && dev_rom[i][pos] != w) mdl_alive[i] = 1'b0;
            resp[2*k+1] = w;
            resp[2*k]   = d;
        end
    endtask

    task automatic exchange(input int g, input logic [7:0] hb, input string tag,
                            input bit drop_en, input bit poke, input bit hold,
                            output logic [7:0] got, output logic [7:0] expb);
        int n, r0, b0;
        string t;
        model_group(g, hb, expb);
        t = tag;
        if (drop_en) t = {t, " R12"};
        if (poke) t = {t, " R2"};
        r0 = rise_cnt;
        b0 = bad_pulse;
        @(negedge clk);
        tx_byte = hb;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        if (drop_en) search_en = 1'b0;
        n = 1;
        check(busy == 1'b1, "R2", "busy after accepted load", busy, 1);
        while (!rx_full && n < GROUP_CYC + 50) begin
            if (poke && n == 10) begin tx_byte = ~hb; tx_load = 1'b1; end
            else tx_load = 1'b0;
            @(negedge clk);
            n++;
        end
        tx_load = 1'b0;
        check(n == GROUP_CYC + 1, {t, " R8"}, "rx_full latency", n, GROUP_CYC + 1);
        check(rx_byte == expb, {t, " R7"}, $sformatf("response group %0d", g), rx_byte, expb);
        check(rise_cnt - r0 == 12, "R3", "slots per group", rise_cnt - r0, 12);
        check(bad_pulse == b0, "R3", "pulse widths", bad_pulse - b0, 0);
        got = rx_byte;
        search_en = 1'b1;
        if (hold) begin
            repeat (30) @(negedge clk);
            check(rx_full == 1'b1, "R9", "rx_full held without ack", rx_full, 1);
            check(rx_byte == expb, "R9", "rx_byte held", rx_byte, expb);
        end
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        check(rx_full == 1'b0, "R9", "rx_full cleared by ack", rx_full, 0);
    endtask

    task automatic run_search(input logic [3:0] present, input logic [7:0] hint_base,
                              input bit vary, input string tag,
                              input int drop_g, input int poke_g, input int hold_g,
                              output logic [63:0] id, output logic [63:0] exp_id);
        logic [7:0] got, expb, hb;
        dev_present = present;
        mdl_alive = present;
        @(posedge clk);
        dev_restart = 1'b1;
        @(posedge clk);
        dev_restart = 1'b0;
        id = '0;
        exp_id = '0;
        for (int g = 0; g < 16; g++) begin
            hb = vary ? (hint_base ^ {g[3:0], g[3:0]}) : hint_base;
            exchange(g, hb, tag, g == drop_g, g == poke_g, g == hold_g, got, expb);
            for (int k = 0; k < 4; k++) begin
                id[4*g+k]     = got[2*k+1];
                exp_id[4*g+k] = expb[2*k+1];
            end
        end
        check(id == exp_id, {tag, " R10"}, "assembled identity", id, exp_id);
    endtask

    function automatic bit is_member(input logic [63:0] id, input logic [3:0] present);
        is_member = 1'b0;
        for (int i = 0; i < 4; i++)
            if (present[i] && dev_rom[i] == id) is_member = 1'b1;
    endfunction

    // ---------------- main sequence ----------------
    task automatic main_seq();
        logic [63:0] id, eid;
        bit seen_busy, seen_drive, seen_full;

        dev_rom[0] = 64'h3A00_0001_6C2D_9F14;
        dev_rom[1] = 64'h3A00_0001_6C2D_9D14;
        dev_rom[2] = 64'h7E00_00F0_1234_5601;
        dev_rom[3] = 64'hC100_0000_0000_00A8;

        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(rx_full == 1'b0, "R1", "rx_full in reset", rx_full, 0);
        check(line_drive_low == 1'b0, "R1", "line in reset", line_drive_low, 0);
        check(rx_byte == 8'h00, "R1", "rx_byte in reset", rx_byte, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && rx_full == 1'b0, "R1", "idle after reset", {busy, rx_full}, 0);

        // Load with the accelerator disabled is ignored.
        tx_byte = 8'hAA;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        seen_busy = 0; seen_drive = 0; seen_full = 0;
        repeat (40) begin
            if (busy) seen_busy = 1;
            if (line_drive_low) seen_drive = 1;
            if (rx_full) seen_full = 1;
            @(negedge clk);
        end
        check(!seen_busy, "R2", "busy on disabled load", seen_busy, 0);
        check(!seen_drive, "R2", "line on disabled load", seen_drive, 0);
        check(!seen_full, "R2", "rx_full on disabled load", seen_full, 0);

        search_en = 1'b1;

        run_search(4'b0001, 8'h00, 0, "R5", -1, -1, 2, id, eid);
        check(id == dev_rom[0], "R10", "single device identity", id, dev_rom[0]);

        run_search(4'b0011, 8'h00, 0, "R4 R11", -1, -1, -1, id, eid);
        check(id == dev_rom[1], "R11", "zero hints pick the 0 branch", id, dev_rom[1]);

        run_search(4'b0011, 8'hAA, 0, "R4", -1, -1, -1, id, eid);
        check(id == dev_rom[0], "R4", "one hints pick the 1 branch", id, dev_rom[0]);

        run_search(4'b0111, 8'h5A, 1, "R4 R5", 3, 5, -1, id, eid);
        check(is_member(id, 4'b0111), "R10", "identity is a present device", id, eid);

        run_search(4'b0000, 8'h00, 0, "R6", -1, -1, -1, id, eid);
        check(id == 64'hFFFF_FFFF_FFFF_FFFF, "R6", "empty line identity", id, 64'hFFFF_FFFF_FFFF_FFFF);

        run_search(4'b1111, 8'hC3, 1, "R4 R5", -1, 9, -1, id, eid);
        check(is_member(id, 4'b1111), "R10", "identity is a present device", id, eid);

        @(negedge clk);
        check(busy == 1'b0 && line_drive_low == 1'b0, "R3", "quiet when idle",
              {busy, line_drive_low}, 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule